// File: doc/BRIEF.md
# Retriggerable Dual-Input One-Shot Pulse Generator

This block produces a single high pulse on `pulse_o`, with its complement on `pulse_n_o`, whenever one of three trigger conditions is met. Two trigger pins act in opposite senses: `trig_fall_i` fires on a high-to-low change and `trig_rise_i` fires on a low-to-high change. Each pin's level gates the other pin's edge, so either pin can hold off triggers from its partner. An active-low clear aborts any pulse and blocks all triggers. When the clear is released, a pulse also starts if the two trigger pins are at their enabling levels.

The pulse length is a whole number of clock cycles taken from a width register, loaded through a write strobe. A trigger that arrives while a pulse is running reloads the timer to the full width, so the pulse is extended. All three pins may be asynchronous to the clock. Each passes through a two-stage synchronizer, so a pin change shows on the outputs three rising clock edges after it is applied.

Top module: `retrig_oneshot`

## Requirements
- R1: With clear high and `trig_rise_i` high, a high-to-low change on `trig_fall_i` starts a pulse. `pulse_o` is first high after the third rising clock edge following the pin change.
- R2: With clear high and `trig_fall_i` low, a low-to-high change on `trig_rise_i` starts a pulse, with the same three-edge latency as R1.
- R3: `trig_fall_i` high blocks every trigger, and `trig_rise_i` low blocks every trigger. This includes a clear release.
- R4: While `clr_n_i` is low, `pulse_o` is forced low and `pulse_n_o` high from the third rising edge after the clear falls. Any running pulse is cut short, and no trigger takes effect.
- R5: A low-to-high change on `clr_n_i`, while `trig_fall_i` is low and `trig_rise_i` is high, starts a pulse with the same three-edge latency.
- R6: A qualified trigger during a running pulse reloads the timer. A retrigger applied k cycles after the first trigger, with k not above the width W, gives one unbroken pulse of k+W cycles.
- R7: `pulse_n_o` is always the complement of `pulse_o`.
- R8: A pulse lasts exactly W clock cycles, where W is the value last written through `width_we_i`/`width_i`. A written value of 0 gives 1 cycle. A write made during a pulse does not change that pulse; it applies from the next trigger.
- R9: After reset, `pulse_o` is low, `pulse_n_o` is high and the width is the parameter default (4). The synchronizers start as if `trig_fall_i` were high, `trig_rise_i` low and `clr_n_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_fall_i | input | 1 | Trigger on falling edge; its high level inhibits other triggers |
| trig_rise_i | input | 1 | Trigger on rising edge; its low level inhibits other triggers |
| clr_n_i | input | 1 | Active-low clear; its rising edge can fire a pulse |
| width_we_i | input | 1 | Write strobe for the width register |
| width_i | input | 8 | Pulse width in clock cycles (0 treated as 1) |
| pulse_o | output | 1 | Pulse output, high while timing |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The hardest case to reach from the pins is a second qualified edge that lands at an exact cycle offset inside a running pulse. Every pin edge passes through the synchronizers before it is seen, so the offset has to be set at the pins. The bench starts a pulse with a falling edge on one pin. It then drops the other pin low and raises it again exactly k cycles later, sweeping k across the whole pulse for several widths. It measures the length of the single merged pulse against k+W. A clear asserted mid-pulse is handled the same way: the bench drives it at a known cycle and checks the exact cycle on which the pulse is cut.

// File: rtl/ros_pkg.sv
// Package: shared types for the retriggerable one-shot.
// Assumes: pin bundle order clear/rise/fall is only used internally.
package ros_pkg;

    // Bundle of the three trigger-related pins, carried together through sync.
    typedef struct packed {
        logic clr_n;
        logic rise_in;
        logic fall_in;
    } pins_t;

    // Which condition qualified a pulse start in the current cycle.
    typedef enum logic [1:0] {
        FIRE_NONE  = 2'd0,
        FIRE_FALL  = 2'd1,
        FIRE_RISE  = 2'd2,
        FIRE_CLEAR = 2'd3
    } fire_e;

    // Levels assumed at reset: both trigger pins inhibiting, clear released.
    localparam pins_t PINS_IDLE = '{clr_n: 1'b1, rise_in: 1'b0, fall_in: 1'b1};

endpackage

// File: rtl/ros_sync.sv
// Module: ros_sync
// Multi-stage synchronizer for a vector of asynchronous level inputs.
// Assumes: each bit is independent; no bus coherence is required.
module ros_sync #(
    parameter int               BITS    = 3,
    parameter int               STAGES  = 2,
    parameter logic [BITS-1:0]  RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] async_i,
    output logic [BITS-1:0] sync_o
);

    logic [BITS-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw asynchronous levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Shift the previous stage onward to settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ros_trigger_qual.sv
// Module: ros_trigger_qual
// Detects edges on the synchronized pins and decides whether a pulse starts.
// Assumes: inputs are already synchronous; one cycle of history suffices.
module ros_trigger_qual
    import ros_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t lvl_i,
    output fire_e cause_o,
    output logic  clr_ok_o
);

    pins_t prev_q;
    logic  fall_edge;
    logic  rise_edge;
    logic  clr_edge;
    logic  fall_enables;
    logic  rise_enables;

    // Keep the previous synchronized levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= PINS_IDLE;
        else        prev_q <= lvl_i;
    end

    // Edges and enabling levels derived from current versus previous levels.
    always_comb begin
        fall_edge    = prev_q.fall_in & ~lvl_i.fall_in;
        rise_edge    = ~prev_q.rise_in & lvl_i.rise_in;
        clr_edge     = ~prev_q.clr_n & lvl_i.clr_n;
        fall_enables = ~lvl_i.fall_in;
        rise_enables = lvl_i.rise_in;
    end

    // Qualify: clear must be high; each edge is gated by the partner level.
    always_comb begin
        cause_o = FIRE_NONE;
        if (lvl_i.clr_n) begin
            if (clr_edge && fall_enables && rise_enables)
                cause_o = FIRE_CLEAR;
            else if (fall_edge && rise_enables)
                cause_o = FIRE_FALL;
            else if (rise_edge && fall_enables)
                cause_o = FIRE_RISE;
        end
    end

    assign clr_ok_o = lvl_i.clr_n;

endmodule

// File: rtl/ros_pulse_timer.sv
// Module: ros_pulse_timer
// Holds the programmed width and counts the pulse down; drives Q and Q-bar.
// Assumes: fire and clr_ok are synchronous; clear dominates fire.
module ros_pulse_timer #(
    parameter int WB          = 8,
    parameter int RESET_WIDTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [WB-1:0] wdata_i,
    input  logic          fire_i,
    input  logic          clr_ok_i,
    output logic          q_o,
    output logic          qn_o,
    output logic [WB-1:0] cnt_o,
    output logic [WB-1:0] width_eff_o
);

    localparam logic [WB-1:0] RST_W = WB'(RESET_WIDTH);
    localparam logic [WB-1:0] ONE   = WB'(1);

    logic [WB-1:0] width_q;
    logic [WB-1:0] cnt_q;
    logic [WB-1:0] cnt_d;
    logic          q_q;
    logic          qn_q;

    // Width register, written only through the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    width_q <= RST_W;
        else if (we_i) width_q <= wdata_i;
    end

    // A programmed zero behaves as one cycle.
    assign width_eff_o = (width_q == '0) ? ONE : width_q;

    // Next count: clear wins, then reload on trigger, else count down.
    always_comb begin
        if (!clr_ok_i)         cnt_d = '0;
        else if (fire_i)       cnt_d = width_eff_o;
        else if (cnt_q != '0)  cnt_d = cnt_q - ONE;
        else                   cnt_d = '0;
    end

    // Counter and both outputs registered from the next count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            q_q   <= 1'b0;
            qn_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            q_q   <= (cnt_d != '0);
            qn_q  <= (cnt_d == '0);
        end
    end

    assign q_o   = q_q;
    assign qn_o  = qn_q;
    assign cnt_o = cnt_q;

endmodule

// File: rtl/retrig_oneshot.sv
// Module: retrig_oneshot (top)
// Retriggerable one-shot with falling/rising trigger pins and active-low clear.
// Assumes: pins are asynchronous; width port is synchronous to clk.
module retrig_oneshot
    import ros_pkg::*;
#(
    parameter int WB          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_WIDTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_fall_i,
    input  logic          trig_rise_i,
    input  logic          clr_n_i,
    input  logic          width_we_i,
    input  logic [WB-1:0] width_i,
    output logic          pulse_o,
    output logic          pulse_n_o
);

    localparam int PIN_BITS = $bits(pins_t);

    pins_t         pins_raw;
    pins_t         pins_lvl;
    fire_e         cause;
    logic          fire;
    logic          clr_ok;
    logic          fall_lvl;
    logic          rise_lvl;
    logic [WB-1:0] cnt;
    logic [WB-1:0] width_eff;

    // Gather the raw pins into one bundle for the synchronizer.
    always_comb begin
        pins_raw.clr_n   = clr_n_i;
        pins_raw.rise_in = trig_rise_i;
        pins_raw.fall_in = trig_fall_i;
    end

    ros_sync #(
        .BITS    (PIN_BITS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_BITS'(PINS_IDLE))
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_lvl)
    );

    ros_trigger_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (pins_lvl),
        .cause_o  (cause),
        .clr_ok_o (clr_ok)
    );

    assign fire     = (cause != FIRE_NONE);
    assign fall_lvl = pins_lvl.fall_in;
    assign rise_lvl = pins_lvl.rise_in;

    ros_pulse_timer #(
        .WB          (WB),
        .RESET_WIDTH (RESET_WIDTH)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (width_we_i),
        .wdata_i     (width_i),
        .fire_i      (fire),
        .clr_ok_i    (clr_ok),
        .q_o         (pulse_o),
        .qn_o        (pulse_n_o),
        .cnt_o       (cnt),
        .width_eff_o (width_eff)
    );

endmodule

// File: rtl/ros_checker.sv
// Module: ros_checker
// Temporal properties of the one-shot, bound onto the top module.
// Assumes: connected to the top's synchronized levels and timer state.
module ros_checker #(
    parameter int WB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pulse_o,
    input logic          pulse_n_o,
    input logic          fire,
    input logic          clr_ok,
    input logic          fall_lvl,
    input logic          rise_lvl,
    input logic [WB-1:0] cnt,
    input logic [WB-1:0] width_eff
);

    p_first_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(fire));

    p_fall_pin_inhibits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_lvl |-> !fire);

    p_rise_pin_inhibits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_lvl |-> !fire);

    p_clear_blocks_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_ok |-> !fire);

    p_clear_forces_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_ok |=> (!pulse_o && pulse_n_o));

    p_reload_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pulse_o && cnt == $past(width_eff)));

    p_complement_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o != pulse_n_o);

    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && !fire && cnt != '0) |=> (cnt == WB'($past(cnt) - 1'b1)));

    p_min_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        width_eff != '0);

endmodule

bind retrig_oneshot ros_checker #(.WB(WB)) u_ros_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_o   (pulse_o),
    .pulse_n_o (pulse_n_o),
    .fire      (fire),
    .clr_ok    (clr_ok),
    .fall_lvl  (fall_lvl),
    .rise_lvl  (rise_lvl),
    .cnt       (cnt),
    .width_eff (width_eff)
);

// File: tb/retrig_oneshot_bench.sv
// Bench: sweeps widths, trigger kinds, retrigger offsets and clear timing.
module retrig_oneshot_bench;

    localparam int WB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a = 1'b1;
    logic          b = 1'b0;
    logic          clr = 1'b1;
    logic          we = 1'b0;
    logic [WB-1:0] wd = '0;
    logic          q;
    logic          qn;

    int n_chk = 0;
    int n_fail = 0;
    int m_highs, m_first, m_rises, m_comp;

    always #4 clk = ~clk;

    retrig_oneshot #(.WB(WB)) u_retrig_oneshot (
        .clk (clk), .rst_n (rst_n), .trig_fall_i (a), .trig_rise_i (b),
        .clr_n_i (clr), .width_we_i (we), .width_i (wd),
        .pulse_o (q), .pulse_n_o (qn)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample after each of the next 'window' rising edges, at the falling edge.
    task automatic measure(input int window);
        logic prev_q;
        m_highs = 0; m_first = -1; m_rises = 0; m_comp = 0;
        prev_q = q;
        for (int i = 1; i <= window; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (q === qn) m_comp++;
            if (q === 1'b1) begin
                m_highs++;
                if (m_first < 0) m_first = i;
                if (prev_q !== 1'b1) m_rises++;
            end
            prev_q = q;
        end
    endtask

    task automatic check_pulse(input string req, input int exp);
        check(m_highs == exp, req, m_highs, exp);
        if (exp > 0) begin
            check(m_first == 3, {req, " start"}, m_first, 3);
            check(m_rises == 1, {req, " single"}, m_rises, 1);
        end
        check(m_comp == 0, "R7 complement", m_comp, 0);
    endtask

    task automatic set_width(input int v);
        @(negedge clk);
        we = 1'b1; wd = WB'(v);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        a = 1'b1; b = 1'b0; clr = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic kick_fall();
        b = 1'b1;
        repeat (5) @(negedge clk);
        a = 1'b0;
    endtask

    task automatic kick_rise();
        a = 1'b0;
        repeat (5) @(negedge clk);
        b = 1'b1;
    endtask

    task automatic kick_clear();
        clr = 1'b0;
        repeat (5) @(negedge clk);
        a = 1'b0; b = 1'b1;
        repeat (5) @(negedge clk);
        clr = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        int exp;
        repeat (4) @(negedge clk);
        check(q == 1'b0, "R9 reset q", int'(q), 0);
        check(qn == 1'b1, "R9 reset qn", int'(qn), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(q == 1'b0 && qn == 1'b1, "R9 idle after reset", int'(q), 0);

        // R9: default width is 4 without any write.
        idle();
        kick_fall(); measure(12); check_pulse("R9 default width", 4);

        // R1 R2 R5 R8: width sweep over each trigger kind.
        for (int w = 0; w <= 12; w++) begin
            exp = (w == 0) ? 1 : w;
            set_width(w);
            idle(); kick_fall();  measure(exp + 8); check_pulse("R1 fall trigger R8", exp);
            idle(); kick_rise();  measure(exp + 8); check_pulse("R2 rise trigger R8", exp);
            idle(); kick_clear(); measure(exp + 8); check_pulse("R5 clear release R8", exp);
        end

        // R6: retrigger via rising pin k cycles after a falling-pin start.
        for (int w = 5; w <= 7; w++) begin
            set_width(w);
            for (int k = 2; k <= w; k++) begin
                idle();
                kick_fall();
                fork
                    measure(w + k + 8);
                    begin
                        @(negedge clk);
                        b = 1'b0;
                        repeat (k - 1) @(negedge clk);
                        b = 1'b1;
                    end
                join
                check_pulse("R6 retrigger", w + k);
            end
        end

        // R3: inhibits by level.
        idle();
        a = 1'b0; measure(10); check_pulse("R3 fall with rise-pin low", 0);
        idle();
        b = 1'b1; measure(10); check_pulse("R3 rise with fall-pin high", 0);
        idle();
        clr = 1'b0; b = 1'b1; repeat (5) @(negedge clk);
        clr = 1'b1; measure(10); check_pulse("R3 clear release with fall-pin high", 0);

        // R4: clear mid-pulse cuts it on the third edge.
        set_width(10);
        idle(); kick_fall();
        repeat (4) @(negedge clk);
        clr = 1'b0;
        measure(12);
        check(m_highs == 2, "R4 abort length", m_highs, 2);
        check(m_first == 1, "R4 abort still high", m_first, 1);
        check(m_comp == 0, "R7 complement", m_comp, 0);
        // R4: triggers ignored while clear low.
        a = 1'b1; repeat (5) @(negedge clk);
        a = 1'b0; measure(10); check_pulse("R4 fall ignored in clear", 0);
        a = 1'b1; repeat (5) @(negedge clk);
        b = 1'b0; a = 1'b0; repeat (5) @(negedge clk);
        b = 1'b1; measure(10); check_pulse("R4 rise ignored in clear", 0);

        // R8: write during a pulse affects only the next trigger.
        set_width(8);
        idle(); kick_fall();
        fork
            measure(18);
            begin
                repeat (4) @(negedge clk);
                we = 1'b1; wd = WB'(3);
                @(negedge clk);
                we = 1'b0;
            end
        join
        check_pulse("R8 width held during pulse", 8);
        idle(); kick_fall(); measure(12); check_pulse("R8 new width next trigger", 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule